// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache with Access Rights Check

This block turns a virtual address into a physical address for three kinds of access: load, store and instruction fetch. A request also carries a privilege flag that selects either the user or the supervisor rights. The block keeps a direct-mapped array of raw page-table entries. Each slot is selected by the low bits of the virtual page number and is tagged with the whole virtual page number. When the slot holds a valid entry with a matching tag, the block answers one cycle after it accepts the request. In that answer it either combines the frame number of the entry with the page offset, or reports an access fault whose code depends on the kind of access.

When the lookup misses, the block holds a request on a walker port until the walker returns an entry. If that entry is valid, the block installs it in the slot and answers from it. If it is invalid, the block reports a fault and leaves the slot as it was. The translation base register is written through its own port. A write stores the value rounded down to a page boundary and clears every stored entry. A write that arrives while a walk is pending also stops that walk's result from being installed.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, walk_req is 0 and base_q is 0.
- R2: A request that misses raises walk_req, with walk_vaddr equal to the request address, until walk_ack. A valid returned entry is installed, so a later access to the same virtual page hits and raises no new walk.
- R3: The slot index is virtual page number (vaddr >> 12) modulo 256. A hit also needs the stored tag to equal the full virtual page number, so two pages that share a slot evict each other.
- R4: An entry whose bit 1 is clear, whether stored or returned by the walker, gives a fault and is never installed.
- R5: In user mode the rights bit checked in the entry is bit 6 for a load, bit 5 for a store and bit 4 for a fetch. The access faults when that bit is 0.
- R6: In supervisor mode the checked bit is the user bit plus 3 (load bit 9, store bit 8, fetch bit 7). The user bits alone grant nothing there.
- R7: rsp_fault is 0 when the access is allowed. On a fault it is 1 for a load, 2 for a store and 3 for a fetch. req_kind encodes 0 load, 1 store, 2 fetch, and code 3 is treated as a load for both the rights bit and the fault code.
- R8: When the access is allowed, rsp_paddr is {entry[31:12], vaddr[11:0]}. On a fault it is 0.
- R9: A write to base_we sets base_q to base_wdata with bits 11:0 cleared and invalidates all entries, so a page that hit before the write misses after it.
- R10: If the base register is written while a walk is pending, the returned entry is still used for that response but is not installed.
- R11: rsp_valid lasts exactly one cycle per accepted request, and req_ready is 0 while a walk is pending.
- R12: A hit is answered in the cycle after acceptance, and a miss is answered in the cycle after walk_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_super | input | 1 | Supervisor privilege when 1 |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 load, 2 store, 3 fetch fault |
| walk_req | output | 1 | Walk request, held until walk_ack |
| walk_vaddr | output | 32 | Address to be walked |
| walk_ack | input | 1 | Walker result valid |
| walk_entry | input | 32 | Raw entry returned by the walker |
| base_we | input | 1 | Write the translation base register |
| base_wdata | input | 32 | Value to write |
| base_q | output | 32 | Page-aligned base register |

## Verification
The main function is driven with entries that carry all rights, entries that carry a single rights bit, and entries with the valid bit clear. A single-bit entry shows whether the right bit position is selected for each of the six kind and mode combinations, and whether the fault code follows the kind. Each entry is used once on the walk path and once on the hit path, which shows whether both paths apply the same check. Two pages that share a slot test whether the full tag is compared. A base write before an access, and another during a pending walk, show the difference between clearing the stored slots and blocking a stale install.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_ALT   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LOAD  = 2'd1,
      FLT_STORE = 2'd2,
      FLT_FETCH = 2'd3
   } fault_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } ctrl_st_e;

   // entry layout
   localparam int ENT_VALID_BIT  = 1;
   localparam int RIGHTS_LSB     = 4;
   localparam int RIGHTS_W       = 6;
   localparam int PRIV_STEP      = 3;

   // offset of the user rights bit inside the rights field
   function automatic logic [2:0] user_offset(acc_kind_e k);
      case (k)
         ACC_STORE: user_offset = 3'd1;
         ACC_FETCH: user_offset = 3'd0;
         default:   user_offset = 3'd2;
      endcase
   endfunction

   function automatic fault_e fault_code(acc_kind_e k);
      case (k)
         ACC_STORE: fault_code = FLT_STORE;
         ACC_FETCH: fault_code = FLT_FETCH;
         default:   fault_code = FLT_LOAD;
      endcase
   endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
   parameter int ENT_W = 32,
   parameter int TAG_W = 20,
   parameter int DEPTH = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [ENT_W-1:0] wr_entry,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic [ENT_W-1:0] rd_entry
);

   logic [ENT_W-1:0] ent_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_q[i] <= '0;
            tag_q[i] <= '0;
         end
      end else if (flush) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_q[i] <= '0;
         end
      end else if (wr_en) begin
         ent_q[wr_idx] <= wr_entry;
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign rd_entry = ent_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
#(
   parameter int ENT_W    = 32,
   parameter int PG_SHIFT = 12
) (
   input  logic [ENT_W-1:0]    entry,
   input  logic [PG_SHIFT-1:0] voffset,
   input  acc_kind_e           kind,
   input  logic                super_mode,
   output fault_e              fault,
   output logic [ENT_W-1:0]    paddr
);

   logic [2:0]          sel_off;
   logic [RIGHTS_W-1:0] need;
   logic [RIGHTS_W-1:0] have;
   logic                granted;
   logic                allowed;

   assign sel_off = user_offset(kind) + (super_mode ? 3'(PRIV_STEP) : 3'd0);
   assign have    = entry[RIGHTS_LSB +: RIGHTS_W];

   for (genvar g = 0; g < RIGHTS_W; g++) begin : g_need
      assign need[g] = (sel_off == 3'(g));
   end

   assign granted = |(need & have);
   assign allowed = entry[ENT_VALID_BIT] & granted;
   assign fault   = allowed ? FLT_NONE : fault_code(kind);
   assign paddr   = allowed ? {entry[ENT_W-1:PG_SHIFT], voffset} : '0;

   logic unused_perm_bits;
   assign unused_perm_bits = ^{entry[PG_SHIFT-1:RIGHTS_LSB+RIGHTS_W],
                               entry[RIGHTS_LSB-1:ENT_VALID_BIT+1],
                               entry[ENT_VALID_BIT-1:0]};

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
   import tlb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic hit,
   input  logic flush,
   input  logic walk_ack,
   input  logic walk_ok,
   output logic req_ready,
   output logic capture,
   output logic sel_walk,
   output logic walk_req,
   output logic install,
   output logic rsp_load
);

   ctrl_st_e st_q;
   logic     stale_q;
   logic     accept;
   logic     idle;

   assign idle      = (st_q == ST_IDLE);
   assign req_ready = idle & ~flush;
   assign accept    = req_valid & req_ready;
   assign capture   = accept;
   assign sel_walk  = ~idle;
   assign walk_req  = ~idle;
   assign rsp_load  = (accept & hit) | (~idle & walk_ack);
   assign install   = ~idle & walk_ack & walk_ok & ~stale_q & ~flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         stale_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept && !hit) begin
                  st_q    <= ST_WALK;
                  stale_q <= 1'b0;
               end
            end
            default: begin
               if (flush) stale_q <= 1'b1;
               if (walk_ack) st_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int ENT_W    = 32,
   parameter int PG_SHIFT = 12,
   parameter int ENTRIES  = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic             req_super,
   output logic             rsp_valid,
   output logic [ENT_W-1:0] rsp_paddr,
   output logic [1:0]       rsp_fault,
   output logic             walk_req,
   output logic [VA_W-1:0]  walk_vaddr,
   input  logic             walk_ack,
   input  logic [ENT_W-1:0] walk_entry,
   input  logic             base_we,
   input  logic [ENT_W-1:0] base_wdata,
   output logic [ENT_W-1:0] base_q
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int VPN_W = VA_W - PG_SHIFT;

   if (ENTRIES != (1 << IDX_W)) begin : g_bad_depth
      initial $fatal(1, "ENTRIES must be a power of two");
   end
   if (VPN_W < IDX_W) begin : g_bad_vpn
      initial $fatal(1, "virtual page number narrower than index");
   end
   if (PG_SHIFT < RIGHTS_LSB + RIGHTS_W || ENT_W <= PG_SHIFT) begin : g_bad_entry
      initial $fatal(1, "entry layout does not fit page shift");
   end

   logic             capture, sel_walk, install, rsp_load, hit;
   logic [VA_W-1:0]  held_vaddr;
   acc_kind_e        held_kind;
   logic             held_super;
   logic [VA_W-1:0]  lk_vaddr;
   acc_kind_e        lk_kind;
   logic             lk_super;
   logic [VPN_W-1:0] lk_vpn;
   logic [VPN_W-1:0] rd_tag;
   logic [ENT_W-1:0] rd_entry;
   logic [ENT_W-1:0] use_entry;
   fault_e           p_fault;
   logic [ENT_W-1:0] p_paddr;

   assign lk_vaddr  = sel_walk ? held_vaddr : req_vaddr;
   assign lk_kind   = sel_walk ? held_kind  : acc_kind_e'(req_kind);
   assign lk_super  = sel_walk ? held_super : req_super;
   assign lk_vpn    = lk_vaddr[VA_W-1:PG_SHIFT];
   assign hit       = rd_entry[ENT_VALID_BIT] & (rd_tag == lk_vpn);
   assign use_entry = sel_walk ? walk_entry : rd_entry;

   tlb_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .hit       (hit),
      .flush     (base_we),
      .walk_ack  (walk_ack),
      .walk_ok   (walk_entry[ENT_VALID_BIT]),
      .req_ready (req_ready),
      .capture   (capture),
      .sel_walk  (sel_walk),
      .walk_req  (walk_req),
      .install   (install),
      .rsp_load  (rsp_load)
   );

   tlb_store #(
      .ENT_W (ENT_W),
      .TAG_W (VPN_W),
      .DEPTH (ENTRIES)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (base_we),
      .wr_en    (install),
      .wr_idx   (lk_vpn[IDX_W-1:0]),
      .wr_tag   (lk_vpn),
      .wr_entry (walk_entry),
      .rd_idx   (lk_vpn[IDX_W-1:0]),
      .rd_tag   (rd_tag),
      .rd_entry (rd_entry)
   );

   tlb_perm #(
      .ENT_W    (ENT_W),
      .PG_SHIFT (PG_SHIFT)
   ) u_perm (
      .entry      (use_entry),
      .voffset    (lk_vaddr[PG_SHIFT-1:0]),
      .kind       (lk_kind),
      .super_mode (lk_super),
      .fault      (p_fault),
      .paddr      (p_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_vaddr <= '0;
         held_kind  <= ACC_LOAD;
         held_super <= 1'b0;
      end else if (capture) begin
         held_vaddr <= req_vaddr;
         held_kind  <= acc_kind_e'(req_kind);
         held_super <= req_super;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_fault <= FLT_NONE;
      end else begin
         rsp_valid <= rsp_load;
         if (rsp_load) begin
            rsp_paddr <= p_paddr;
            rsp_fault <= p_fault;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_we) begin
         base_q <= {base_wdata[ENT_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
      end
   end

   assign walk_vaddr = held_vaddr;

   logic unused_base_low;
   assign unused_base_low = ^base_wdata[PG_SHIFT-1:0];

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W     = 32,
   parameter int ENT_W    = 32,
   parameter int PG_SHIFT = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [ENT_W-1:0] rsp_paddr,
   input logic [1:0]       rsp_fault,
   input logic             walk_req,
   input logic [VA_W-1:0]  walk_vaddr,
   input logic             walk_ack,
   input logic             base_we,
   input logic [ENT_W-1:0] base_wdata,
   input logic [ENT_W-1:0] base_q
);

   // R11
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R11
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |-> !req_ready);

   // R2
   walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vaddr)));

   // R12
   walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_ack) |=> (rsp_valid && !walk_req));

   // R12
   accept_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (rsp_valid || walk_req));

   // R9
   base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |=> (base_q[ENT_W-1:PG_SHIFT] == $past(base_wdata[ENT_W-1:PG_SHIFT])
                   && base_q[PG_SHIFT-1:0] == '0));

   // R8
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VA_W     (VA_W),
   .ENT_W    (ENT_W),
   .PG_SHIFT (PG_SHIFT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_paddr  (rsp_paddr),
   .rsp_fault  (rsp_fault),
   .walk_req   (walk_req),
   .walk_vaddr (walk_vaddr),
   .walk_ack   (walk_ack),
   .base_we    (base_we),
   .base_wdata (base_wdata),
   .base_q     (base_q)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic [1:0]  rsp_fault;
   logic        walk_req;
   logic [31:0] walk_vaddr;
   logic        walk_ack = 1'b0;
   logic [31:0] walk_entry = '0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic [31:0] base_q;

   int          checks = 0;
   int          errors = 0;
   int          walk_cnt = 0;
   logic [31:0] wk_entry = 32'h000003F2;
   logic [31:0] wk_seen_va = '0;
   logic        flush_walk = 1'b0;
   logic [31:0] flush_val = 32'h0BAD_C123;

   always #10 clk = ~clk;

   tlb_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_super(req_super),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_ack(walk_ack),
      .walk_entry(walk_entry), .base_we(base_we), .base_wdata(base_wdata),
      .base_q(base_q)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // walker model
   initial begin
      forever begin
         @(negedge clk);
         if (walk_req && !walk_ack) begin
            walk_cnt++;
            wk_seen_va = walk_vaddr;
            if (flush_walk) begin
               base_we = 1'b1;
               base_wdata = flush_val;
               @(negedge clk);
               base_we = 1'b0;
            end else begin
               @(negedge clk);
            end
            @(negedge clk);
            walk_entry = wk_entry;
            walk_ack = 1'b1;
            @(negedge clk);
            walk_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   // expected values straight from the requirements
   function automatic logic [1:0] exp_fault(input logic [1:0] k, input logic s, input logic [31:0] e);
      int pos;
      pos = 4 + ((k == 2'd1) ? 1 : (k == 2'd2) ? 0 : 2) + (s ? 3 : 0);
      if (e[1] && e[pos]) return 2'd0;
      return (k == 2'd1) ? 2'd2 : (k == 2'd2) ? 2'd3 : 2'd1;
   endfunction

   function automatic logic [31:0] exp_pa(input logic [1:0] k, input logic s,
                                          input logic [31:0] e, input logic [31:0] va);
      if (exp_fault(k, s, e) != 2'd0) return 32'h0;
      return {e[31:12], va[11:0]};
   endfunction

   task automatic access(input logic [31:0] va, input logic [1:0] k, input logic s,
                         output logic [31:0] pa, output logic [1:0] f, output int lat);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = va;
      req_kind  = k;
      req_super = s;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      pa = rsp_paddr;
      f  = rsp_fault;
      if (!rsp_valid) chk("R11 response missing", 0, 1);
   endtask

   // access and compare with the expected response for the given entry
   task automatic probe(input string req, input logic [31:0] va, input logic [1:0] k,
                        input logic s, input logic [31:0] e, input logic want_walk);
      logic [31:0] pa;
      logic [1:0]  f;
      int          lat;
      int          w0;
      w0 = walk_cnt;
      access(va, k, s, pa, f, lat);
      chk({req, " fault"}, f, exp_fault(k, s, e));
      chk({req, " paddr"}, pa, exp_pa(k, s, e, va));
      chk({req, " walk count"}, walk_cnt - w0, want_walk ? 1 : 0);
      chk({req, " latency R12"}, lat, want_walk ? 4 : 1);
   endtask

   task automatic t_reset();
      chk("R1 req_ready", req_ready, 1);
      chk("R1 rsp_valid", rsp_valid, 0);
      chk("R1 walk_req", walk_req, 0);
      chk("R1 base_q", base_q, 0);
   endtask

   task automatic t_miss_hit();
      wk_entry = 32'hABCDE3F2;
      probe("R2 first miss", 32'h12345678, 2'd0, 1'b0, wk_entry, 1'b1);
      chk("R2 walk address", wk_seen_va, 32'h12345678);
      probe("R2 hit same page", 32'h12345ABC, 2'd1, 1'b0, wk_entry, 1'b0);
      probe("R2 hit fetch sup", 32'h12345004, 2'd2, 1'b1, wk_entry, 1'b0);
   endtask

   task automatic t_alias();
      logic [31:0] e1;
      e1 = wk_entry;
      wk_entry = 32'h55555FF2;
      probe("R3 alias page misses", 32'h12445010, 2'd0, 1'b0, wk_entry, 1'b1);
      wk_entry = e1;
      probe("R3 first page evicted", 32'h12345010, 2'd0, 1'b0, e1, 1'b1);
      probe("R3 first page back", 32'h12345020, 2'd0, 1'b0, e1, 1'b0);
   endtask

   task automatic t_invalid();
      wk_entry = 32'hABCDE3F0;
      probe("R4 invalid walk load", 32'h00777100, 2'd0, 1'b0, wk_entry, 1'b1);
      probe("R4 invalid not installed", 32'h00777200, 2'd1, 1'b0, wk_entry, 1'b1);
   endtask

   task automatic t_user();
      wk_entry = 32'h11111042;
      probe("R5 user load bit6", 32'h00101000, 2'd0, 1'b0, wk_entry, 1'b1);
      probe("R5 user store denied", 32'h00101004, 2'd1, 1'b0, wk_entry, 1'b0);
      probe("R5 user fetch denied", 32'h00101008, 2'd2, 1'b0, wk_entry, 1'b0);
      probe("R6 user bit no super", 32'h0010100C, 2'd0, 1'b1, wk_entry, 1'b0);
      wk_entry = 32'h22222022;
      probe("R5 user store bit5", 32'h00102000, 2'd1, 1'b0, wk_entry, 1'b1);
      wk_entry = 32'h33333012;
      probe("R5 user fetch bit4", 32'h00103000, 2'd2, 1'b0, wk_entry, 1'b1);
      probe("R7 fetch fault code", 32'h00103010, 2'd0, 1'b0, wk_entry, 1'b0);
   endtask

   task automatic t_super();
      wk_entry = 32'h44444202;
      probe("R6 super load bit9", 32'h00201000, 2'd0, 1'b1, wk_entry, 1'b1);
      probe("R6 user load denied", 32'h00201004, 2'd0, 1'b0, wk_entry, 1'b0);
      wk_entry = 32'h55555102;
      probe("R6 super store bit8", 32'h00202000, 2'd1, 1'b1, wk_entry, 1'b1);
      probe("R7 super fetch fault", 32'h00202004, 2'd2, 1'b1, wk_entry, 1'b0);
      wk_entry = 32'h66666082;
      probe("R6 super fetch bit7", 32'h00203000, 2'd2, 1'b1, wk_entry, 1'b1);
      probe("R7 super store fault", 32'h00203004, 2'd1, 1'b1, wk_entry, 1'b0);
   endtask

   task automatic t_kind3();
      wk_entry = 32'h77777042;
      probe("R7 kind3 as load ok", 32'h00301000, 2'd3, 1'b0, wk_entry, 1'b1);
      wk_entry = 32'h88888022;
      probe("R7 kind3 fault code", 32'h00302000, 2'd3, 1'b0, wk_entry, 1'b1);
   endtask

   task automatic t_paddr();
      wk_entry = 32'hFEDCB3F2;
      probe("R8 paddr offset max", 32'h00401FFF, 2'd0, 1'b1, wk_entry, 1'b1);
      probe("R8 paddr offset zero", 32'h00401000, 2'd1, 1'b0, wk_entry, 1'b0);
   endtask

   task automatic t_base();
      wk_entry = 32'h0A0A03F2;
      probe("R9 install before flush", 32'h00501234, 2'd0, 1'b0, wk_entry, 1'b1);
      @(negedge clk);
      base_we = 1'b1;
      base_wdata = 32'h87654ABC;
      @(negedge clk);
      base_we = 1'b0;
      chk("R9 base aligned", base_q, 32'h87654000);
      probe("R9 miss after flush", 32'h00501234, 2'd0, 1'b0, wk_entry, 1'b1);
      probe("R9 hit after rewalk", 32'h00501238, 2'd0, 1'b0, wk_entry, 1'b0);
   endtask

   task automatic t_flush_walk();
      wk_entry = 32'h0C0C03F2;
      flush_walk = 1'b1;
      probe("R10 response uses walk", 32'h00601100, 2'd0, 1'b0, wk_entry, 1'b1);
      flush_walk = 1'b0;
      chk("R10 base written", base_q, 32'h0BADC000);
      probe("R10 not installed", 32'h00601104, 2'd0, 1'b0, wk_entry, 1'b1);
      probe("R10 later install ok", 32'h00601108, 2'd0, 1'b0, wk_entry, 1'b0);
   endtask

   task automatic t_busy();
      int seen_ready;
      int pulses;
      seen_ready = 0;
      pulses = 0;
      wk_entry = 32'h0D0D03F2;
      @(negedge clk);
      req_vaddr = 32'h00701000;
      req_kind  = 2'd0;
      req_super = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (walk_req && req_ready) seen_ready++;
         if (rsp_valid) pulses++;
         @(negedge clk);
      end
      chk("R11 ready low during walk", seen_ready, 0);
      chk("R11 single response pulse", pulses, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_miss_hit();
      t_alias();
      t_invalid();
      t_user();
      t_super();
      t_kind3();
      t_paddr();
      t_base();
      t_flush_walk();
      t_busy();
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule